// File: doc/BRIEF.md
# Codec Register Access Slot Interface

This block gives a host a way to read and write the control registers of an attached audio codec through a pair of slot words. The host first loads the slot-2 transmit word with the 16-bit value to write. It then writes the slot-1 transmit word, which carries the 7-bit codec register address and a read/write flag. Writing slot 1 launches one transaction on a simple codec register port: a single request cycle that carries the address, the data and a write-enable bit.

For a read, the codec returns a 16-bit value after a fixed latency of 0 or 1 cycles, selected by a parameter. The block stores the result in two slot receive words. The slot-1 receive word is a copy of the slot-1 transmit word with the read flag cleared. The slot-2 receive word holds the returned value moved up into the upper data field.

A flag word reports several conditions: whether each transmit word is still empty, whether a read is in flight, and whether unread results are waiting. Reading a receive word through the host port consumes its valid flag. Serial frame generation is not part of this block.

Top module: `codec_slot_access`

## Requirements
- R1: After reset the flag word reads 0x07, both receive words read zero and no codec request is issued. Flag bit positions: bit0 slot-1 TX empty, bit1 slot-2 TX empty, bit2 both TX empty, bit3 slot-1 RX busy, bit4 slot-2 RX busy, bit5 slot-1 RX valid, bit6 slot-2 RX valid.
- R2: A host write to slot-2 transmit (select 1) stores bits [19:0] of the write data and clears flag bits 1 and 2. Bit 2 is set only while both TX-empty flags are set.
- R3: A host write to slot-1 transmit (select 0) stores bits [19:0] and clears flag bits 0 and 2. In the next cycle it raises `cdc_req` for exactly one cycle. TX-empty flags never set again until reset.
- R4: When bit 19 of the slot-1 word is 0, the request is a write: `cdc_we`=1, `cdc_addr` is slot-1 bits [18:12], and `cdc_wdata` is slot-2 bits [19:4].
- R5: When bit 19 of the slot-1 word is 1, the request is a read: `cdc_we`=0 and `cdc_addr` is slot-1 bits [18:12].
- R6: On read completion, slot-1 receive gets the slot-1 transmit word with bit 19 cleared, and slot-2 receive gets the returned value in bits [19:4] with zeros in bits [3:0]. With READ_LATENCY=1, `cdc_rdata` is taken one cycle after the request cycle, so the result is readable two cycles after the slot-1 write edge.
- R7: Flag bits 3 and 4 are set from the slot-1 write edge of a read until completion, when they clear and bits 5 and 6 set. A write transaction leaves the receive words and flag bits 3 to 6 unchanged.
- R8: A host read strobe on slot-1 receive (select 2) clears only flag bit 5. On slot-2 receive (select 3) it clears only flag bit 6. A completion in the same cycle wins.
- R9: Host writes to selects 2, 3 and 4 are ignored: the receive words and flags keep their values and no request is issued.
- R10: `host_rdata` follows `host_sel` combinationally. Select 0/1 returns the transmit words, 2/3 the receive words, 4 the flags, all zero-extended, and any other select returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (consumes RX valid) |
| host_sel | input | 3 | Host register select |
| host_wdata | input | HOST_W | Host write data |
| host_rdata | output | HOST_W | Host read data for the selected register |
| cdc_req | output | 1 | One-cycle codec register request |
| cdc_we | output | 1 | Request is a write |
| cdc_addr | output | 7 | Codec register address |
| cdc_wdata | output | 16 | Codec write data |
| cdc_rdata | input | 16 | Codec read data |

## Verification
The assertions assume the host does not write slot 1 again until the previous transaction has finished and, for a read, its completion has landed. They also assume the codec presents read data exactly at the configured latency after the request. The stimulus meets both assumptions: every slot-1 write is followed by waiting cycles until the result is visible, and the bench's codec model answers from a registered array one cycle after each request, matching the default latency.

// File: rtl/cdc_slot_pkg.sv
package cdc_slot_pkg;

    localparam int SLOT_W  = 20;
    localparam int CADDR_W = 7;
    localparam int CDATA_W = 16;
    localparam int SEL_W   = 3;
    localparam int RW_BIT  = SLOT_W - 1;
    localparam int ADDR_HI = SLOT_W - 2;
    localparam int DATA_LO = SLOT_W - CDATA_W;

    typedef enum logic [SEL_W-1:0] {
        SEL_S1TX  = 3'd0,
        SEL_S2TX  = 3'd1,
        SEL_S1RX  = 3'd2,
        SEL_S2RX  = 3'd3,
        SEL_FLAGS = 3'd4
    } host_sel_e;

    // bit0 is the last member
    typedef struct packed {
        logic s2_rx_valid;
        logic s1_rx_valid;
        logic s2_rx_busy;
        logic s1_rx_busy;
        logic both_tx_empty;
        logic s2_tx_empty;
        logic s1_tx_empty;
    } slot_flags_t;

    localparam int FLAGS_W = $bits(slot_flags_t);

    typedef struct packed {
        logic               we;
        logic [CADDR_W-1:0] addr;
        logic [CDATA_W-1:0] data;
    } cdc_cmd_t;

    function automatic logic slot_is_read(input logic [SLOT_W-1:0] w);
        return w[RW_BIT];
    endfunction

    function automatic logic [CADDR_W-1:0] slot_addr(input logic [SLOT_W-1:0] w);
        return w[ADDR_HI -: CADDR_W];
    endfunction

    function automatic logic [CDATA_W-1:0] slot_data(input logic [SLOT_W-1:0] w);
        return w[SLOT_W-1 -: CDATA_W];
    endfunction

    function automatic logic [SLOT_W-1:0] rx1_echo(input logic [SLOT_W-1:0] w);
        logic [SLOT_W-1:0] r;
        r         = w;
        r[RW_BIT] = 1'b0;
        return r;
    endfunction

    function automatic logic [SLOT_W-1:0] rx2_pack(input logic [CDATA_W-1:0] d);
        return {d, {DATA_LO{1'b0}}};
    endfunction

endpackage

// File: rtl/slot_tx_regs.sv
module slot_tx_regs
    import cdc_slot_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_s1,
    input  logic              wr_s2,
    input  logic [SLOT_W-1:0] wword,
    output logic [SLOT_W-1:0] s1_word,
    output logic [SLOT_W-1:0] s2_word,
    output logic              s1_empty,
    output logic              s2_empty
);

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_word  <= '0;
            s2_word  <= '0;
            s1_empty <= 1'b1;
            s2_empty <= 1'b1;
        end else begin
            if (wr_s1) begin
                s1_word  <= wword;
                s1_empty <= 1'b0;
            end
            if (wr_s2) begin
                s2_word  <= wword;
                s2_empty <= 1'b0;
            end
        end
    end

    AST_S1_EMPTY_STICKY: assert property (@(posedge clk) disable iff (rst)
        !s1_empty |=> !s1_empty) else $error("slot-1 TX empty set again"); // R3
    AST_S2_EMPTY_STICKY: assert property (@(posedge clk) disable iff (rst)
        !s2_empty |=> !s2_empty) else $error("slot-2 TX empty set again"); // R2
    AST_S2_STORE: assert property (@(posedge clk) disable iff (rst)
        wr_s2 |=> (s2_word == $past(wword))) else $error("slot-2 word not stored"); // R2

endmodule

// File: rtl/slot_txn_engine.sv
module slot_txn_engine
    import cdc_slot_pkg::*;
#(
    parameter int READ_LATENCY = 1
)(
    input  logic               clk,
    input  logic               rst,
    input  logic               launch,
    input  logic               launch_read,
    input  logic [CADDR_W-1:0] launch_addr,
    input  logic [CDATA_W-1:0] launch_data,
    output logic               cdc_req,
    output logic               cdc_we,
    output logic [CADDR_W-1:0] cdc_addr,
    output logic [CDATA_W-1:0] cdc_wdata,
    input  logic [CDATA_W-1:0] cdc_rdata,
    output logic               rd_start,
    output logic               rd_done,
    output logic [CDATA_W-1:0] rd_value
);

    cdc_cmd_t cmd_q;
    logic     req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= 1'b0;
            cmd_q <= '0;
        end else begin
            req_q <= launch;
            if (launch) begin
                cmd_q.we   <= ~launch_read;
                cmd_q.addr <= launch_addr;
                cmd_q.data <= launch_data;
            end
        end
    end

    assign cdc_req   = req_q;
    assign cdc_we    = cmd_q.we;
    assign cdc_addr  = cmd_q.addr;
    assign cdc_wdata = cmd_q.data;
    assign rd_start  = launch & launch_read;
    assign rd_value  = cdc_rdata;

    generate
        if (READ_LATENCY == 0) begin : g_lat0
            assign rd_done = req_q & ~cmd_q.we;
        end else begin : g_lat1
            logic pend_q;
            always_ff @(posedge clk) begin
                if (rst) pend_q <= 1'b0;
                else     pend_q <= req_q & ~cmd_q.we;
            end
            assign rd_done = pend_q;
        end
    endgenerate

    AST_REQ_FOLLOWS_LAUNCH: assert property (@(posedge clk) disable iff (rst)
        launch |=> cdc_req) else $error("no request after launch"); // R3
    AST_WE_FROM_FLAG: assert property (@(posedge clk) disable iff (rst)
        launch |=> (cdc_we == !$past(launch_read))) else $error("request direction wrong"); // R4
    AST_ADDR_FROM_SLOT: assert property (@(posedge clk) disable iff (rst)
        launch |=> (cdc_addr == $past(launch_addr))) else $error("request address wrong"); // R5

endmodule

// File: rtl/slot_rx_regs.sv
module slot_rx_regs
    import cdc_slot_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               rd_start,
    input  logic               rd_done,
    input  logic [CDATA_W-1:0] rd_value,
    input  logic [SLOT_W-1:0]  s1_word,
    input  logic               take_rx1,
    input  logic               take_rx2,
    output logic [SLOT_W-1:0]  rx1_word,
    output logic [SLOT_W-1:0]  rx2_word,
    output logic               busy1,
    output logic               busy2,
    output logic               valid1,
    output logic               valid2
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rx1_word <= '0;
            rx2_word <= '0;
            busy1    <= 1'b0;
            busy2    <= 1'b0;
            valid1   <= 1'b0;
            valid2   <= 1'b0;
        end else begin
            if (rd_start) begin
                busy1 <= 1'b1;
                busy2 <= 1'b1;
            end else if (rd_done) begin
                busy1 <= 1'b0;
                busy2 <= 1'b0;
            end
            if (rd_done) begin
                rx1_word <= rx1_echo(s1_word);
                rx2_word <= rx2_pack(rd_value);
                valid1   <= 1'b1;
                valid2   <= 1'b1;
            end else begin
                if (take_rx1) valid1 <= 1'b0;
                if (take_rx2) valid2 <= 1'b0;
            end
        end
    end

    AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
        rd_start |=> (busy1 && busy2)) else $error("busy not set"); // R7
    AST_DONE_SETS_VALID: assert property (@(posedge clk) disable iff (rst)
        rd_done |=> (valid1 && valid2 && !busy1 && !busy2)) else $error("completion flags wrong"); // R7
    AST_RX1_FLAG_CLEARED: assert property (@(posedge clk) disable iff (rst)
        rd_done |=> !rx1_word[RW_BIT]) else $error("echo kept read flag"); // R6
    AST_TAKE_RX1: assert property (@(posedge clk) disable iff (rst)
        (take_rx1 && !rd_done) |=> !valid1) else $error("slot-1 valid not consumed"); // R8
    AST_TAKE_RX2: assert property (@(posedge clk) disable iff (rst)
        (take_rx2 && !rd_done) |=> !valid2) else $error("slot-2 valid not consumed"); // R8

endmodule

// File: rtl/slot_read_mux.sv
module slot_read_mux
    import cdc_slot_pkg::*;
#(
    parameter int HOST_W = 32
)(
    input  logic [SEL_W-1:0]  sel,
    input  logic [SLOT_W-1:0] s1_word,
    input  logic [SLOT_W-1:0] s2_word,
    input  logic [SLOT_W-1:0] rx1_word,
    input  logic [SLOT_W-1:0] rx2_word,
    input  slot_flags_t       flags,
    output logic [HOST_W-1:0] rdata
);

    always_comb begin
        rdata = '0;
        unique case (sel)
            SEL_S1TX:  rdata[SLOT_W-1:0]  = s1_word;
            SEL_S2TX:  rdata[SLOT_W-1:0]  = s2_word;
            SEL_S1RX:  rdata[SLOT_W-1:0]  = rx1_word;
            SEL_S2RX:  rdata[SLOT_W-1:0]  = rx2_word;
            SEL_FLAGS: rdata[FLAGS_W-1:0] = flags;
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/codec_slot_access.sv
module codec_slot_access
    import cdc_slot_pkg::*;
#(
    parameter int HOST_W       = 32,
    parameter int READ_LATENCY = 1
)(
    input  logic               clk,
    input  logic               rst,
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic [SEL_W-1:0]   host_sel,
    input  logic [HOST_W-1:0]  host_wdata,
    output logic [HOST_W-1:0]  host_rdata,
    output logic               cdc_req,
    output logic               cdc_we,
    output logic [CADDR_W-1:0] cdc_addr,
    output logic [CDATA_W-1:0] cdc_wdata,
    input  logic [CDATA_W-1:0] cdc_rdata
);

    logic [SLOT_W-1:0]  wword;
    logic               wr_s1, wr_s2, take_rx1, take_rx2;
    logic [SLOT_W-1:0]  s1_word, s2_word, rx1_word, rx2_word;
    logic               s1_empty, s2_empty;
    logic               rd_start, rd_done;
    logic [CDATA_W-1:0] rd_value;
    logic               busy1, busy2, valid1, valid2;
    slot_flags_t        flags;
    logic               unused_hi;

    assign wword     = host_wdata[SLOT_W-1:0];
    assign unused_hi = ^host_wdata[HOST_W-1:SLOT_W];
    assign wr_s1     = host_wr && (host_sel == SEL_S1TX);
    assign wr_s2     = host_wr && (host_sel == SEL_S2TX);
    assign take_rx1  = host_rd && (host_sel == SEL_S1RX);
    assign take_rx2  = host_rd && (host_sel == SEL_S2RX);

    slot_tx_regs u_tx (
        .clk      (clk),
        .rst      (rst),
        .wr_s1    (wr_s1),
        .wr_s2    (wr_s2),
        .wword    (wword),
        .s1_word  (s1_word),
        .s2_word  (s2_word),
        .s1_empty (s1_empty),
        .s2_empty (s2_empty)
    );

    slot_txn_engine #(.READ_LATENCY(READ_LATENCY)) u_eng (
        .clk         (clk),
        .rst         (rst),
        .launch      (wr_s1),
        .launch_read (slot_is_read(wword)),
        .launch_addr (slot_addr(wword)),
        .launch_data (slot_data(s2_word)),
        .cdc_req     (cdc_req),
        .cdc_we      (cdc_we),
        .cdc_addr    (cdc_addr),
        .cdc_wdata   (cdc_wdata),
        .cdc_rdata   (cdc_rdata),
        .rd_start    (rd_start),
        .rd_done     (rd_done),
        .rd_value    (rd_value)
    );

    slot_rx_regs u_rx (
        .clk      (clk),
        .rst      (rst),
        .rd_start (rd_start),
        .rd_done  (rd_done),
        .rd_value (rd_value),
        .s1_word  (s1_word),
        .take_rx1 (take_rx1),
        .take_rx2 (take_rx2),
        .rx1_word (rx1_word),
        .rx2_word (rx2_word),
        .busy1    (busy1),
        .busy2    (busy2),
        .valid1   (valid1),
        .valid2   (valid2)
    );

    always_comb begin
        flags.s1_tx_empty   = s1_empty;
        flags.s2_tx_empty   = s2_empty;
        flags.both_tx_empty = s1_empty & s2_empty;
        flags.s1_rx_busy    = busy1;
        flags.s2_rx_busy    = busy2;
        flags.s1_rx_valid   = valid1;
        flags.s2_rx_valid   = valid2;
    end

    slot_read_mux #(.HOST_W(HOST_W)) u_mux (
        .sel      (host_sel),
        .s1_word  (s1_word),
        .s2_word  (s2_word),
        .rx1_word (rx1_word),
        .rx2_word (rx2_word),
        .flags    (flags),
        .rdata    (host_rdata)
    );

    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (cdc_req && !wr_s1) |=> !cdc_req) else $error("request longer than one cycle"); // R3
    AST_IGNORED_WRITE: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_sel != SEL_S1TX && !rd_done) |=> ($stable(rx1_word) && $stable(rx2_word)))
        else $error("receive word changed by host write"); // R9

endmodule

// File: tb/codec_slot_access_test.sv
`timescale 1ns/1ps
module codec_slot_access_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [2:0]  host_sel = 3'd0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        cdc_req, cdc_we;
    logic [6:0]  cdc_addr;
    logic [15:0] cdc_wdata;
    logic [15:0] cdc_rdata;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    codec_slot_access uut (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
        .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .cdc_req(cdc_req), .cdc_we(cdc_we), .cdc_addr(cdc_addr),
        .cdc_wdata(cdc_wdata), .cdc_rdata(cdc_rdata)
    );

    function automatic logic [15:0] init_val(input int i);
        return 16'(16'hC300 + i * 37);
    endfunction

    // codec model: register array, read data one cycle after the request
    logic [15:0] cmem [128];
    logic [15:0] crd_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 128; i++) cmem[i] <= init_val(i);
            crd_q <= '0;
        end else if (cdc_req) begin
            if (cdc_we) cmem[cdc_addr] <= cdc_wdata;
            else        crd_q <= cmem[cdc_addr];
        end
    end
    assign cdc_rdata = crd_q;

    logic [15:0] exp_mem [128];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_sel = sel; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_take(input logic [2:0] sel);
        @(negedge clk);
        host_rd = 1'b1; host_sel = sel;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic peek(input logic [2:0] sel, output logic [31:0] v);
        host_sel = sel;
        #1;
        v = host_rdata;
    endtask

    // {read, addr[6:0], data[15:0]}
    localparam logic [23:0] VEC [8] = '{
        {1'b0, 7'h02, 16'h1234},
        {1'b0, 7'h7F, 16'hFFFF},
        {1'b1, 7'h02, 16'h0000},
        {1'b1, 7'h7F, 16'h0000},
        {1'b1, 7'h00, 16'h0000},
        {1'b0, 7'h00, 16'h0000},
        {1'b1, 7'h00, 16'h0000},
        {1'b1, 7'h26, 16'h0000}
    };

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, s1w, last_rx1, last_rx2;
        for (int i = 0; i < 128; i++) exp_mem[i] = init_val(i);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        peek(3'd4, v); chk("R1 flags", v, 32'h07);
        peek(3'd2, v); chk("R1 rx1", v, 0);
        peek(3'd3, v); chk("R1 rx2", v, 0);
        chk("R1 req", {31'b0, cdc_req}, 0);

        // R2 slot-2 write, upper bits dropped
        host_write(3'd1, 32'hFFFA_BCDE);
        peek(3'd1, v); chk("R2 store", v, 32'h000A_BCDE);
        peek(3'd4, v); chk("R2 flags", v, 32'h01);
        chk("R2 no req", {31'b0, cdc_req}, 0);

        // R10 unmapped select
        peek(3'd5, v); chk("R10 unmapped", v, 0);
        peek(3'd7, v); chk("R10 unmapped7", v, 0);

        last_rx1 = 0; last_rx2 = 0;
        for (int k = 0; k < 8; k++) begin
            logic        rd;
            logic [6:0]  a;
            logic [15:0] d;
            {rd, a, d} = VEC[k];
            s1w = {12'b0, rd, a, 12'(k * 12'h111 + 5)};
            if (!rd) begin
                host_write(3'd1, {12'b0, d, 4'h9});
                host_write(3'd0, s1w);
                chk("R3 req", {31'b0, cdc_req}, 1);
                chk("R4 we", {31'b0, cdc_we}, 1);
                chk("R4 addr", {25'b0, cdc_addr}, {25'b0, a});
                chk("R4 wdata", {16'b0, cdc_wdata}, {16'b0, d});
                peek(3'd0, v); chk("R3 store", v, s1w);
                peek(3'd4, v); chk("R3 flags", v, 0);
                @(negedge clk);
                chk("R3 one cycle", {31'b0, cdc_req}, 0);
                exp_mem[a] = d;
                @(negedge clk);
                peek(3'd2, v); chk("R7 write rx1", v, last_rx1);
                peek(3'd3, v); chk("R7 write rx2", v, last_rx2);
                peek(3'd4, v); chk("R7 write flags", v, 0);
            end else begin
                host_write(3'd0, s1w);
                chk("R3 req rd", {31'b0, cdc_req}, 1);
                chk("R5 we", {31'b0, cdc_we}, 0);
                chk("R5 addr", {25'b0, cdc_addr}, {25'b0, a});
                peek(3'd4, v); chk("R7 busy", v, 32'h18);
                @(negedge clk);
                chk("R3 one cycle rd", {31'b0, cdc_req}, 0);
                peek(3'd4, v); chk("R7 busy hold", v, 32'h18);
                @(negedge clk);
                last_rx1 = s1w & ~32'h8_0000;
                last_rx2 = {12'b0, exp_mem[a], 4'h0};
                peek(3'd2, v); chk("R6 rx1 echo", v, last_rx1);
                peek(3'd3, v); chk("R6 rx2 data", v, last_rx2);
                peek(3'd4, v); chk("R7 valid", v, 32'h60);
                if (k == 3) begin
                    // R9 writes to receive and flag selects are ignored
                    host_write(3'd2, 32'h0);
                    chk("R9 no req", {31'b0, cdc_req}, 0);
                    host_write(3'd3, 32'hFFFFF);
                    host_write(3'd4, 32'h0);
                    peek(3'd2, v); chk("R9 rx1", v, last_rx1);
                    peek(3'd3, v); chk("R9 rx2", v, last_rx2);
                    peek(3'd4, v); chk("R9 flags", v, 32'h60);
                end
                host_take(3'd2);
                peek(3'd4, v); chk("R8 take rx1", v, 32'h40);
                host_take(3'd3);
                peek(3'd4, v); chk("R8 take rx2", v, 32'h00);
            end
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule